// File: doc/BRIEF.md
# Single-Qubit State-Vector Gate Engine

This block owns an on-chip amplitude memory holding the complex state vector of an N-qubit register (2^N entries). Each amplitude is one 32-bit word: the real part sits in bits 31:16 and the imaginary part in bits 15:0. Both parts are 16-bit two's-complement Q1.14 values, so 16384 stands for 1.0. A host fills and inspects the vector through a plain word port while the engine is not busy.

A one-cycle `start` pulse, with a 2-bit gate code and a target qubit index, launches one gate. The engine walks every pair of indices that differ only in the target bit. For each pair it reads both amplitudes, computes the two new amplitudes and writes them back in place. A one-cycle `done` pulse marks the end. If the target index is out of range, the engine raises a one-cycle `err` pulse and does not touch memory.

The controller is a state machine with these states: IDLE, RD_I (fetch the low amplitude), RD_J (fetch the high amplitude), CALC (register both results), WR_I (store the low result), WR_J (store the high result), DONE (completion pulse) and REJ (rejection pulse). Its transitions are:
- IDLE to RD_I on a start with a valid target.
- IDLE to REJ on a start with a bad target.
- RD_I to RD_J to CALC to WR_I to WR_J, one step per cycle.
- WR_J back to RD_I while pairs remain, or to DONE after the last pair.
- DONE and REJ return to IDLE after one cycle.

Top module: `qubit_gate_engine`

## Requirements
- R1: After reset, `busy`, `done` and `err` are all 0.
- R2: For target t, the engine processes exactly the indices i whose bit t is 0, pairing each with j = i | (1<<t), in ascending order of i. Every entry of the vector belongs to exactly one pair.
- R3: Gate code 2'b00 (Hadamard) writes round((a0+a1)·11585/16384) to i and round((a0−a1)·11585/16384) to j. This applies to the real and imaginary parts separately. The rounding is floor((p+8192)/16384), and the result saturates to the range [−32768, 32767].
- R4: Gate code 2'b01 (bit flip) swaps the two amplitudes of every pair exactly.
- R5: Gate code 2'b10 writes (a1.im, −a1.re) to i and (−a0.im, a0.re) to j. Every negation saturates, so −(−32768) becomes 32767.
- R6: Gate code 2'b11 (phase flip) leaves index i unchanged and writes (−a1.re, −a1.im) to j, with saturating negation.
- R7: Each pair takes exactly 5 cycles. If start is sampled at clock edge 0, then `busy` is high after edges 0 through 5P−1, where P = 2^(N−1). `done` is high for exactly one cycle, after edge 5P, and `busy` is low in that cycle.
- R8: A start whose target is greater than or equal to N gives `err` high for exactly one cycle, after the sampling edge. It gives no `done`, never raises `busy`, and leaves the memory unchanged.
- R9: A start pulse that arrives while `busy` is high is ignored. The running gate keeps its code and target and finishes on its normal schedule.
- R10: When `busy` is low, a `host_we` pulse writes `host_wdata` to `host_addr`, and `host_rdata` always shows the word at `host_addr` combinationally. When `busy` is high, host writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that launches a gate |
| gate_code | input | 2 | Gate select, sampled with start |
| target | input | TGT_W | Target qubit index, sampled with start |
| busy | output | 1 | High while pairs are being processed |
| done | output | 1 | One-cycle pulse when the gate has finished |
| err | output | 1 | One-cycle pulse on a rejected target |
| host_we | input | 1 | Host word write strobe (honoured only when not busy) |
| host_addr | input | NQ | Host word address |
| host_wdata | input | 32 | Host write data {re, im} |
| host_rdata | output | 32 | Word at host_addr {re, im} |

## Verification
The hardest situations to reach from the ports are a second start and a host write that land in the middle of a sweep. Both must be shown to have no effect. The stimulus raises a start with a different code and target, and a host write, some cycles into a phase-flip sweep. The host write goes to index 0, which that gate passes through unchanged. A write that was wrongly accepted would therefore stay visible in memory and show up in the final comparison. The saturation corners are reached by loading −32768 and 32767 amplitudes, so the Hadamard sums and differences, as well as the negations, overflow.

// File: rtl/qg_pkg.sv
package qg_pkg;

    localparam int AMP_W = 16;
    localparam logic signed [15:0] RSQRT2_Q14 = 16'sd11585;

    typedef enum logic [1:0] {
        G_HAD = 2'b00,
        G_PX  = 2'b01,
        G_PY  = 2'b10,
        G_PZ  = 2'b11
    } gate_e;

    typedef struct packed {
        logic signed [AMP_W-1:0] re;
        logic signed [AMP_W-1:0] im;
    } amp_t;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_I, S_RD_J, S_CALC, S_WR_I, S_WR_J, S_DONE, S_REJ
    } state_e;

    function automatic logic signed [15:0] sat16(input logic signed [33:0] v);
        if (v > 34'sd32767)       return 16'sd32767;
        else if (v < -34'sd32768) return 16'sh8000;
        else                      return $signed(v[15:0]);
    endfunction

    function automatic logic signed [15:0] neg16(input logic signed [15:0] x);
        return sat16(-34'(x));
    endfunction

    function automatic logic signed [15:0] hscale(input logic signed [16:0] s);
        logic signed [33:0] p;
        p = 34'(s) * 34'(RSQRT2_Q14);
        return sat16((p + 34'sd8192) >>> 14);
    endfunction

endpackage

// File: rtl/qg_amp_mem.sv
module qg_amp_mem #(
    parameter int AW = 4,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] ram [DEPTH];

    always_ff @(posedge clk) begin
        if (we) ram[waddr] <= wdata;
    end

    assign rdata_a = ram[raddr_a];
    assign rdata_b = ram[raddr_b];
endmodule

// File: rtl/qg_pair_addr.sv
module qg_pair_addr #(
    parameter int NQ    = 4,
    parameter int TGT_W = 4
) (
    input  logic [NQ-2:0]    k,
    input  logic [TGT_W-1:0] tgt,
    output logic [NQ-1:0]    idx_lo,
    output logic [NQ-1:0]    idx_hi
);
    logic [NQ-1:0] kx, bit_t, low;

    always_comb begin
        kx     = NQ'(k);
        bit_t  = NQ'(1) << tgt;
        low    = bit_t - NQ'(1);
        idx_lo = ((kx & ~low) << 1) | (kx & low);
        idx_hi = idx_lo | bit_t;
    end
endmodule

// File: rtl/qg_gate_alu.sv
module qg_gate_alu
    import qg_pkg::*;
(
    input  gate_e code,
    input  amp_t  a0,
    input  amp_t  a1,
    output amp_t  n0,
    output amp_t  n1
);
    logic signed [16:0] sr, si, dr, di;

    always_comb begin
        sr = 17'(a0.re) + 17'(a1.re);
        si = 17'(a0.im) + 17'(a1.im);
        dr = 17'(a0.re) - 17'(a1.re);
        di = 17'(a0.im) - 17'(a1.im);
        n0 = a0;
        n1 = a1;
        unique case (code)
            G_HAD: begin
                n0 = '{re: hscale(sr), im: hscale(si)};
                n1 = '{re: hscale(dr), im: hscale(di)};
            end
            G_PX: begin
                n0 = a1;
                n1 = a0;
            end
            G_PY: begin
                n0 = '{re: a1.im,        im: neg16(a1.re)};
                n1 = '{re: neg16(a0.im), im: a0.re};
            end
            G_PZ: begin
                n0 = a0;
                n1 = '{re: neg16(a1.re), im: neg16(a1.im)};
            end
        endcase
    end
endmodule

// File: rtl/qubit_gate_engine.sv
module qubit_gate_engine
    import qg_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int TGT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       gate_code,
    input  logic [TGT_W-1:0] target,
    output logic             busy,
    output logic             done,
    output logic             err,
    input  logic             host_we,
    input  logic [NQ-1:0]    host_addr,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata
);
    localparam int KW = NQ - 1;
    localparam logic [KW-1:0] K_LAST = '1;
    localparam logic [TGT_W-1:0] T_LIM = TGT_W'(NQ);

    state_e st, nst;
    logic [KW-1:0]    k;
    logic [TGT_W-1:0] tgt_q;
    gate_e            code_q;
    amp_t             a0, a1, n0, n1, alu0, alu1;
    logic [NQ-1:0]    pair_i, pair_j, raddr, waddr;
    logic [31:0]      rd_eng, wdata;
    logic             eng_we, mem_we;

    qg_pair_addr #(.NQ(NQ), .TGT_W(TGT_W)) u_addr (
        .k(k), .tgt(tgt_q), .idx_lo(pair_i), .idx_hi(pair_j));

    qg_gate_alu u_alu (.code(code_q), .a0(a0), .a1(a1), .n0(alu0), .n1(alu1));

    qg_amp_mem #(.AW(NQ), .W(32)) u_mem (
        .clk(clk), .we(mem_we), .waddr(waddr), .wdata(wdata),
        .raddr_a(raddr), .rdata_a(rd_eng),
        .raddr_b(host_addr), .rdata_b(host_rdata));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nst;
    end

    // next-state logic
    always_comb begin
        nst = st;
        unique case (st)
            S_IDLE: if (start) nst = (target >= T_LIM) ? S_REJ : S_RD_I;
            S_RD_I: nst = S_RD_J;
            S_RD_J: nst = S_CALC;
            S_CALC: nst = S_WR_I;
            S_WR_I: nst = S_WR_J;
            S_WR_J: nst = (k == K_LAST) ? S_DONE : S_RD_I;
            S_DONE: nst = S_IDLE;
            S_REJ:  nst = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k      <= '0;
            tgt_q  <= '0;
            code_q <= G_HAD;
            a0     <= '0;
            a1     <= '0;
            n0     <= '0;
            n1     <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (start && target < T_LIM) begin
                    k      <= '0;
                    tgt_q  <= target;
                    code_q <= gate_e'(gate_code);
                end
                S_RD_I: a0 <= rd_eng;
                S_RD_J: a1 <= rd_eng;
                S_CALC: begin
                    n0 <= alu0;
                    n1 <= alu1;
                end
                S_WR_J: k <= k + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs and memory control
    always_comb begin
        busy   = (st != S_IDLE) && (st != S_DONE) && (st != S_REJ);
        done   = (st == S_DONE);
        err    = (st == S_REJ);
        eng_we = (st == S_WR_I) || (st == S_WR_J);
        raddr  = (st == S_RD_J) ? pair_j : pair_i;
        mem_we = eng_we || (host_we && !busy);
        if (st == S_WR_I) begin
            waddr = pair_i;
            wdata = n0;
        end else if (st == S_WR_J) begin
            waddr = pair_j;
            wdata = n1;
        end else begin
            waddr = host_addr;
            wdata = host_wdata;
        end
    end

    // R2: low index never has the target bit set
    a_r2_low_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((pair_i & (NQ'(1) << tgt_q)) == '0));
    // R2: the two indices of a pair differ in a single bit
    a_r2_pair_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(pair_i ^ pair_j) == 1));
    // R7: completion is a single-cycle pulse following the last write
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(st) == S_WR_J));
    // R8: a rejection only follows a start taken while idle
    a_r8_err_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(start) && !$past(busy)));
    // R9: captured gate and target stay fixed through a sweep
    a_r9_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(tgt_q) && $stable(code_q)));
endmodule

// File: tb/sim_qubit_gate_engine.sv
module sim_qubit_gate_engine;
    localparam int NQ = 4;
    localparam int TGT_W = 4;
    localparam int DEPTH = 1 << NQ;
    localparam int NP = DEPTH / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] gate_code = 2'b00;
    logic [TGT_W-1:0] target = '0;
    logic busy, done, err;
    logic host_we = 1'b0;
    logic [NQ-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int total = 0;
    int bad = 0;
    logic [31:0] model [DEPTH];

    always #2 clk = ~clk;

    qubit_gate_engine #(.NQ(NQ), .TGT_W(TGT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .gate_code(gate_code),
        .target(target), .busy(busy), .done(done), .err(err),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int hs(input longint s);
        return sat((s * 11585 + 8192) >>> 14);
    endfunction

    function automatic logic [31:0] pk(input int re, input int im);
        return {re[15:0], im[15:0]};
    endfunction

    function automatic int re_of(input logic [31:0] w);
        return int'($signed(w[31:16]));
    endfunction

    function automatic int im_of(input logic [31:0] w);
        return int'($signed(w[15:0]));
    endfunction

    // reference in-place gate on the bench model
    task automatic model_apply(input int code, input int t);
        for (int i = 0; i < DEPTH; i++) begin
            if (((i >> t) & 1) == 0) begin
                int j = i | (1 << t);
                int r0 = re_of(model[i]);
                int i0 = im_of(model[i]);
                int r1 = re_of(model[j]);
                int i1 = im_of(model[j]);
                case (code)
                    0: begin
                        model[i] = pk(hs(r0 + r1), hs(i0 + i1));
                        model[j] = pk(hs(r0 - r1), hs(i0 - i1));
                    end
                    1: begin
                        model[i] = pk(r1, i1);
                        model[j] = pk(r0, i0);
                    end
                    2: begin
                        model[i] = pk(i1, sat(-r1));
                        model[j] = pk(sat(-i0), r0);
                    end
                    default: model[j] = pk(sat(-r1), sat(-i1));
                endcase
            end
        end
    endtask

    task automatic host_write(input int a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1;
        host_addr = NQ'(a);
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic load_pattern(input int seed);
        for (int a = 0; a < DEPTH; a++) begin
            model[a] = pk(((a * 3001 + seed) % 16384) - 8192,
                          ((a * 1777 + seed * 7) % 20000) - 10000);
            host_write(a, model[a]);
        end
    endtask

    task automatic check_mem(input string req);
        int miss = 0;
        longint fa = 0, fe = 0;
        @(negedge clk);
        for (int a = 0; a < DEPTH; a++) begin
            host_addr = NQ'(a);
            #0.5;
            if (host_rdata !== model[a]) begin
                if (miss == 0) begin
                    fa = longint'(host_rdata);
                    fe = longint'(model[a]);
                end
                miss++;
            end
        end
        chk(miss == 0, req, fa, fe);
    endtask

    // inj: 0 none, 1 stray start mid-sweep, 2 host write to index 0 mid-sweep
    task automatic run_gate(input int code, input int t, input string req, input int inj);
        int n = 0;
        int done_at = -1;
        int done_cnt = 0;
        int busy_bad = 0;
        int err_cnt = 0;
        model_apply(code, t);
        @(negedge clk);
        start = 1'b1;
        gate_code = 2'(code);
        target = TGT_W'(t);
        while (n < 5 * NP + 6) begin
            @(negedge clk);
            n++;
            if (n == 1) start = 1'b0;
            if (inj == 1 && n == 10) begin
                start = 1'b1;
                gate_code = 2'b01;
                target = '0;
            end
            if (inj == 1 && n == 11) start = 1'b0;
            if (inj == 2 && n == 12) begin
                host_we = 1'b1;
                host_addr = '0;
                host_wdata = 32'h1234_5678;
            end
            if (inj == 2 && n == 13) host_we = 1'b0;
            if (n <= 5 * NP && busy !== 1'b1) busy_bad++;
            if (n > 5 * NP && busy !== 1'b0) busy_bad++;
            if (done === 1'b1) begin
                done_cnt++;
                if (done_at < 0) done_at = n;
            end
            if (err === 1'b1) err_cnt++;
        end
        chk(done_at == 5 * NP + 1, {req, " R7 done timing"}, done_at, 5 * NP + 1);
        chk(done_cnt == 1 && err_cnt == 0, {req, " R7 single done"}, done_cnt, 1);
        chk(busy_bad == 0, {req, " R7 busy window"}, busy_bad, 0);
        check_mem(req);
    endtask

    task automatic run_bad_target(input int t);
        int n = 0;
        int err_at = -1;
        int err_cnt = 0;
        int other = 0;
        @(negedge clk);
        start = 1'b1;
        gate_code = 2'b01;
        target = TGT_W'(t);
        while (n < 12) begin
            @(negedge clk);
            n++;
            if (n == 1) start = 1'b0;
            if (err === 1'b1) begin
                err_cnt++;
                if (err_at < 0) err_at = n;
            end
            if (done === 1'b1 || busy === 1'b1) other++;
        end
        chk(err_at == 1 && err_cnt == 1, "R8 err pulse", err_at, 1);
        chk(other == 0, "R8 no done/busy", other, 0);
        check_mem("R8 memory unchanged");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 reset outputs",
            {busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 after release",
            {busy, done, err}, 0);

        // R10: host load and readback
        load_pattern(11);
        check_mem("R10 host readback");

        // R3 / R2: Hadamard on bit 0 and bit 2
        run_gate(0, 0, "R3 hadamard t0", 0);
        load_pattern(37);
        run_gate(0, 2, "R3 R2 hadamard t2", 0);

        // R3: saturation corners
        for (int a = 0; a < DEPTH; a++) model[a] = '0;
        model[0] = pk(32767, -32768);
        model[1] = pk(32767, -32768);
        model[2] = pk(-32768, 16384);
        model[3] = pk(32767, 0);
        for (int a = 0; a < DEPTH; a++) host_write(a, model[a]);
        run_gate(0, 0, "R3 hadamard saturate", 0);

        // R4 / R2: swap on top bit and bit 1
        load_pattern(5);
        run_gate(1, NQ - 1, "R4 R2 swap top bit", 0);
        run_gate(1, 1, "R4 swap t1", 0);

        // R5: code 10 with an extreme value
        load_pattern(91);
        model[4] = pk(-32768, -32768);
        host_write(4, model[4]);
        run_gate(2, 1, "R5 y gate", 0);

        // R6: phase flip with extreme value at the high index
        load_pattern(23);
        model[12] = pk(-32768, 100);
        host_write(12, model[12]);
        run_gate(3, 2, "R6 phase flip", 0);

        // R8: out of range targets
        run_bad_target(NQ);
        run_bad_target(15);

        // R9: stray start while busy
        load_pattern(64);
        run_gate(3, 1, "R9 start ignored", 1);

        // R10: host write while busy ignored (index 0 passes through unchanged)
        load_pattern(77);
        run_gate(3, 0, "R10 busy host write", 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule